// File: doc/BRIEF.md
# Biphase Data Line Word Decoder

This block pulls a short programming record out of the biphase-coded data line that a broadcaster inserts on one video line of the first field. A timebase supplies a level gate that is high only while that line is on air. A clock recovery stage supplies a one-cycle strobe for each half-bit cell, together with the sliced data level. While the gate is high, the block pairs half-cells into bits. It then hunts for an 8-bit start pattern within a limited number of bit periods. Once the pattern is found, it decodes a payload of fifteen 8-bit words.

Only five of the fifteen words are kept: the four-word run 11 to 14 and the single word 5. They are packed into a 40-bit staging word, with the run first and word 5 last. The bit values are not changed. Every kept bit is checked for a biphase violation, meaning two equal half-cells. When the gate falls, the block gives a one-cycle completion pulse. A success flag is raised with that pulse only if the start code was found, all fifteen words arrived, and no kept bit was in error. A downstream stage then decides whether to latch the staging word.

Top module: `bpd_top`

## Requirements
- R1: After reset, line_done and line_ok are 0 and word_out is all ones.
- R2: Half-cell strobes are taken only while line_gate is high, and not in the cycle that line_gate rises. Strobes outside the gate do not disturb the pairing of the next line.
- R3: Word capture starts only after the START_CODE pattern (default 8'hA5, first received bit compared with the MSB) is matched on the most recent decoded bits. Without a match, the line ends with line_ok = 0 and word_out all ones.
- R4: The start code is accepted only if its last bit is at most bit number SEARCH_BITS (default 24) counted from the gate's rise. A later match is ignored and the line fails.
- R5: The first strobe after the gate rises is the first half of a bit. The bit value is the first half-cell.
- R6: Payload words are numbered 1 to 15 after the start code, and bits arrive MSB first. word_out[39:32], [31:24], [23:16] and [15:8] hold words 11, 12, 13 and 14, and word_out[7:0] holds word 5.
- R7: Equal half-cells in any bit of a kept word force line_ok to 0. The same violation in a word that is not kept has no effect on line_ok.
- R8: If the gate falls before all fifteen payload words have been received, line_ok is 0.
- R9: line_done is a single-cycle pulse that appears on the clock edge after the gate's falling edge is seen. line_ok is only ever high together with line_done.
- R10: A rising gate abandons the previous line's state: it clears the error flag and resets word_out to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | input | 1 | One-cycle strobe per recovered half-bit cell |
| data_in | input | 1 | Sliced data level, sampled with half_en |
| line_gate | input | 1 | High for the duration of the data line in the first field |
| line_done | output | 1 | One-cycle pulse marking the end of the line |
| line_ok | output | 1 | Capture error-free and complete, valid with line_done |
| word_out | output | 40 | Staging word: words 11 to 14 followed by word 5 |

## Verification
A wrong half-cell phase or a miscounted bit position does not show up until line_done. There it appears as a shifted or rotated byte in word_out, or as line_ok falling where an error-free line was sent. The sweeps therefore compare the full 40-bit word at the end of every line. An error detector tied to the wrong word shows up as a wrong line_ok at the same pulse. The search-window sweep places the start code at the exact limit and one bit past it, so an off-by-one in the window changes the result of a single line.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_CAPT   = 2'd2,
      ST_HOLD   = 2'd3
   } bpd_state_e;

   // payload word number mapped to staging slot s (slot 0 lands in the top byte)
   function automatic int slot_word(input int s, input int run_first,
                                    input int run_len, input int solo);
      return (s < run_len) ? (run_first + s) : solo;
   endfunction

endpackage

// File: rtl/bpd_halfpair.sv
module bpd_halfpair (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic take,
   input  logic din,
   output logic bit_vld,
   output logic bit_val,
   output logic bit_err
);
   logic phase;
   logic first_half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= 1'b0;
         first_half <= 1'b0;
         bit_vld    <= 1'b0;
         bit_val    <= 1'b0;
         bit_err    <= 1'b0;
      end else begin
         bit_vld <= 1'b0;
         if (clear) begin
            phase   <= 1'b0;
            bit_err <= 1'b0;
         end else if (take) begin
            if (!phase) begin
               first_half <= din;
               phase      <= 1'b1;
            end else begin
               bit_vld <= 1'b1;
               bit_val <= first_half;
               bit_err <= (first_half == din);
               phase   <= 1'b0;
            end
         end
      end
   end

   // R5: two halves are needed per bit, so decoded bits never come back to back
   assert_pair_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |=> !bit_vld);

endmodule

// File: rtl/bpd_start_search.sv
module bpd_start_search #(
   parameter int          CODE_W      = 8,
   parameter logic [7:0]  START_CODE  = 8'hA5,
   parameter int          SEARCH_BITS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic en,
   input  logic bit_val,
   output logic hit,
   output logic expire
);
   localparam int CW = $clog2(SEARCH_BITS + 1);

   logic [CODE_W-1:0] win;
   logic [CW-1:0]     cnt;
   logic [CODE_W-1:0] cand;

   generate
      if (CODE_W < 2 || CODE_W > 8) begin : g_bad_code
         $error("CODE_W out of range");
      end
      if (SEARCH_BITS < CODE_W) begin : g_bad_window
         $error("SEARCH_BITS shorter than start code");
      end
   endgenerate

   assign cand = {win[CODE_W-2:0], bit_val};

   always_comb begin
      hit    = en && (cnt >= CW'(CODE_W - 1)) && (cnt < CW'(SEARCH_BITS))
               && (cand == START_CODE[CODE_W-1:0]);
      expire = en && !hit && (cnt == CW'(SEARCH_BITS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win <= '0;
         cnt <= '0;
      end else if (clear) begin
         win <= '0;
         cnt <= '0;
      end else if (en) begin
         win <= cand;
         if (cnt != CW'(SEARCH_BITS)) cnt <= cnt + 1'b1;
      end
   end

   // R4: once the window has closed the controller stops feeding this search
   assert_no_search_after_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !en);

endmodule

// File: rtl/bpd_word_capture.sv
module bpd_word_capture #(
   parameter int WORD_W    = 8,
   parameter int WORDS     = 15,
   parameter int RUN_FIRST = 11,
   parameter int RUN_LEN   = 4,
   parameter int SOLO_WORD = 5,
   localparam int KEEP_N   = RUN_LEN + 1,
   localparam int STAGE_W  = KEEP_N * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               en,
   input  logic               bit_val,
   input  logic               bit_err,
   output logic [STAGE_W-1:0] stage,
   output logic               err,
   output logic               full,
   output logic               last
);
   localparam int PW  = $clog2(WORD_W);
   localparam int WNW = $clog2(WORDS + 1);

   logic [PW-1:0]      pos;
   logic [WNW-1:0]     wnum;
   logic [KEEP_N-1:0]  slot_hit;
   logic [STAGE_W-1:0] wr_sel;
   logic               kept;

   generate
      for (genvar s = 0; s < KEEP_N; s++) begin : g_slot
         localparam int WNUM = bpd_pkg::slot_word(s, RUN_FIRST, RUN_LEN, SOLO_WORD);
         localparam int LSB  = (KEEP_N - 1 - s) * WORD_W;
         assign slot_hit[s] = (wnum == WNW'(WNUM));
         for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            assign wr_sel[LSB + b] = en && slot_hit[s] && (pos == PW'(WORD_W - 1 - b));
         end
      end
   endgenerate

   assign kept = |slot_hit;
   assign last = en && (wnum == WNW'(WORDS)) && (pos == PW'(WORD_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '1;
         err   <= 1'b0;
         full  <= 1'b0;
         pos   <= '0;
         wnum  <= WNW'(1);
      end else if (clear) begin
         stage <= '1;
         err   <= 1'b0;
         full  <= 1'b0;
         pos   <= '0;
         wnum  <= WNW'(1);
      end else if (en) begin
         for (int i = 0; i < STAGE_W; i++) begin
            if (wr_sel[i]) stage[i] <= bit_val;
         end
         if (kept && bit_err) err <= 1'b1;
         if (last) full <= 1'b1;
         if (pos == PW'(WORD_W - 1)) begin
            pos  <= '0;
            wnum <= wnum + 1'b1;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   // R6: a completed payload is never extended by further writes
   assert_no_write_after_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !en);
   // R7: the error flag only rises while bits are being captured
   assert_err_only_in_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(en));

endmodule

// File: rtl/bpd_top.sv
module bpd_top #(
   parameter int         WORD_W      = 8,
   parameter int         WORDS       = 15,
   parameter int         RUN_FIRST   = 11,
   parameter int         RUN_LEN     = 4,
   parameter int         SOLO_WORD   = 5,
   parameter int         CODE_W      = 8,
   parameter logic [7:0] START_CODE  = 8'hA5,
   parameter int         SEARCH_BITS = 24
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              half_en,
   input  logic                              data_in,
   input  logic                              line_gate,
   output logic                              line_done,
   output logic                              line_ok,
   output logic [(RUN_LEN+1)*WORD_W-1:0]     word_out
);
   import bpd_pkg::*;

   localparam int STAGE_W = (RUN_LEN + 1) * WORD_W;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (SOLO_WORD < 1 || SOLO_WORD > WORDS) begin : g_bad_solo
         $error("SOLO_WORD outside payload");
      end
      if (RUN_LEN < 1 || RUN_FIRST < 1 || RUN_FIRST + RUN_LEN - 1 > WORDS) begin : g_bad_run
         $error("kept run outside payload");
      end
      if (SOLO_WORD >= RUN_FIRST && SOLO_WORD < RUN_FIRST + RUN_LEN) begin : g_overlap
         $error("SOLO_WORD overlaps the kept run");
      end
   endgenerate

   bpd_state_e state;
   logic gate_q, rise, fall, take;
   logic bit_vld, bit_val, bit_err;
   logic hit, expire;
   logic cap_err, cap_full, cap_last;
   logic [STAGE_W-1:0] stage;

   assign rise = line_gate && !gate_q;
   assign fall = !line_gate && gate_q;
   assign take = half_en && line_gate && !rise
                 && (state == ST_SEARCH || state == ST_CAPT);

   bpd_halfpair u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rise),
      .take    (take),
      .din     (data_in),
      .bit_vld (bit_vld),
      .bit_val (bit_val),
      .bit_err (bit_err)
   );

   bpd_start_search #(
      .CODE_W      (CODE_W),
      .START_CODE  (START_CODE),
      .SEARCH_BITS (SEARCH_BITS)
   ) u_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rise),
      .en      (bit_vld && state == ST_SEARCH),
      .bit_val (bit_val),
      .hit     (hit),
      .expire  (expire)
   );

   bpd_word_capture #(
      .WORD_W    (WORD_W),
      .WORDS     (WORDS),
      .RUN_FIRST (RUN_FIRST),
      .RUN_LEN   (RUN_LEN),
      .SOLO_WORD (SOLO_WORD)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rise),
      .en      (bit_vld && state == ST_CAPT),
      .bit_val (bit_val),
      .bit_err (bit_err),
      .stage   (stage),
      .err     (cap_err),
      .full    (cap_full),
      .last    (cap_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         gate_q    <= 1'b0;
         line_done <= 1'b0;
         line_ok   <= 1'b0;
      end else begin
         gate_q    <= line_gate;
         line_done <= fall;
         line_ok   <= fall && (state == ST_HOLD) && cap_full && !cap_err;
         if (rise) begin
            state <= ST_SEARCH;
         end else if (fall) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_SEARCH: if (hit) state <= ST_CAPT;
                          else if (expire) state <= ST_HOLD;
               ST_CAPT:   if (cap_last) state <= ST_HOLD;
               default:   ;
            endcase
         end
      end
   end

   assign word_out = stage;

   // R9: the success flag never appears outside the completion pulse
   assert_ok_within_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line_ok |-> line_done);
   // R9: completion is a single-cycle pulse
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !line_done);
   // R3: capture is only ever entered from the code search
   assert_capture_after_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPT) |-> $past(state == ST_CAPT || state == ST_SEARCH));
   // R7: a flagged violation in a kept word rules out success at the end of the line
   assert_err_blocks_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && cap_err) |=> !line_ok);

endmodule

// File: tb/tb_bpd_top.sv
module tb_bpd_top;
   localparam logic [7:0] CODE = 8'hA5;
   localparam int LIMIT = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic half_en = 1'b0;
   logic data_in = 1'b0;
   logic line_gate = 1'b0;
   logic line_done, line_ok;
   logic [39:0] word_out;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bpd_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_en   (half_en),
      .data_in   (data_in),
      .line_gate (line_gate),
      .line_done (line_done),
      .line_ok   (line_ok),
      .word_out  (word_out)
   );

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pay(input int seed, input int k);
      return 8'((seed * 37 + k * 29 + 11) & 255);
   endfunction

   task automatic send_half(input logic v);
      @(negedge clk);
      half_en = 1'b1;
      data_in = v;
      @(negedge clk);
      half_en = 1'b0;
   endtask

   task automatic send_bit(input logic b, input bit bad);
      send_half(b);
      send_half(bad ? b : ~b);
   endtask

   // pre: zero bits before the code; code_on: send the code
   // nwords: payload words sent; ew/eb: word and bit given a violation (0 = none)
   task automatic run_line(input int seed, input int pre, input bit code_on,
                           input int nwords, input int ew, input int eb,
                           output logic done_o, output logic ok_o, output logic [39:0] w_o,
                           output logic done_next);
      @(negedge clk);
      line_gate = 1'b1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < pre; i++) send_bit(1'b0, 1'b0);
      if (code_on)
         for (int i = 7; i >= 0; i--) send_bit(CODE[i], 1'b0);
      for (int k = 1; k <= nwords; k++)
         for (int i = 7; i >= 0; i--)
            send_bit(pay(seed, k)[i], (k == ew) && (i == eb));
      repeat (3) @(negedge clk);
      line_gate = 1'b0;
      done_o = 1'b0;
      for (int t = 0; t < 4 && !done_o; t++) begin
         @(negedge clk);
         if (line_done) begin
            done_o = 1'b1;
            ok_o = line_ok;
            w_o = word_out;
         end
      end
      if (!done_o) begin
         ok_o = 1'b0;
         w_o = '0;
      end
      @(negedge clk);
      done_next = line_done;
   endtask

   function automatic logic [39:0] exp_word(input int seed);
      return {pay(seed, 11), pay(seed, 12), pay(seed, 13), pay(seed, 14), pay(seed, 5)};
   endfunction

   initial begin
      logic d, ok, dn;
      logic [39:0] w;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 line_done", {39'd0, line_done}, 40'd0);
      check("R1 line_ok", {39'd0, line_ok}, 40'd0);
      check("R1 word_out", word_out, {40{1'b1}});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R6/R5/R9: clean lines, several payload patterns and preamble lengths
      for (int s = 0; s < 6; s++) begin
         run_line(s, s * 3, 1'b1, 15, 0, 0, d, ok, w, dn);
         check("R9 done pulse", {39'd0, d}, 40'd1);
         check("R9 single cycle", {39'd0, dn}, 40'd0);
         check("R5 line_ok clean", {39'd0, ok}, 40'd1);
         check("R6 word order", w, exp_word(s));
      end

      // R2: stray strobes with the gate low must not shift pairing
      send_half(1'b1);
      send_half(1'b0);
      send_half(1'b1);
      run_line(7, 2, 1'b1, 15, 0, 0, d, ok, w, dn);
      check("R2 ok after stray", {39'd0, ok}, 40'd1);
      check("R2 word after stray", w, exp_word(7));

      // R3: no start code
      run_line(8, 4, 1'b0, 15, 0, 0, d, ok, w, dn);
      check("R3 no code ok", {39'd0, ok}, 40'd0);
      check("R3 no code word", w, {40{1'b1}});

      // R4: code ending exactly at the limit, then one bit late
      run_line(9, LIMIT - 8, 1'b1, 15, 0, 0, d, ok, w, dn);
      check("R4 at limit ok", {39'd0, ok}, 40'd1);
      check("R4 at limit word", w, exp_word(9));
      run_line(10, LIMIT - 7, 1'b1, 15, 0, 0, d, ok, w, dn);
      check("R4 past limit ok", {39'd0, ok}, 40'd0);
      check("R4 past limit word", w, {40{1'b1}});

      // R7: violation swept over every payload word
      for (int k = 1; k <= 15; k++) begin
         logic keep;
         keep = (k == 5) || (k >= 11 && k <= 14);
         run_line(k + 20, 1, 1'b1, 15, k, k % 8, d, ok, w, dn);
         check(keep ? "R7 kept word error" : "R7 dropped word error",
               {39'd0, ok}, {39'd0, !keep});
         check("R7 value kept from first half", w, exp_word(k + 20));
      end

      // R10: a clean line after an errored one is fully ok
      run_line(40, 0, 1'b1, 15, 0, 0, d, ok, w, dn);
      check("R10 recovers ok", {39'd0, ok}, 40'd1);
      check("R10 recovers word", w, exp_word(40));

      // R8: truncated payload
      run_line(41, 0, 1'b1, 12, 0, 0, d, ok, w, dn);
      check("R8 truncated ok", {39'd0, ok}, 40'd0);

      // R10: next line after truncation resets staging
      run_line(42, 0, 1'b0, 0, 0, 0, d, ok, w, dn);
      check("R10 staging reset", w, {40{1'b1}});
      check("R10 no stale ok", {39'd0, ok}, 40'd0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule